// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. It keeps an accumulator and a packed status byte. For each operation it receives an opcode and a second operand byte through a valid/ready handshake. The operand is first captured in a temporary register that no program can see. On the next clock edge the selected operation runs against the accumulator. The result goes back into the accumulator, or only into the flags for compare, or out on a result port for increment and decrement of a non-accumulator operand.

The status byte carries sign, zero, nibble carry, even parity and carry in a fixed layout. Another unit can therefore decode it by bit position. `in_ready_o` is tied high: the block never applies back-pressure, and a new operation may be offered on every cycle. An operation accepted at clock edge k has its effect visible on the outputs after edge k+1. Back-to-back operations see each other's results, because each one reads the accumulator and flags in its own execute cycle.

Top module: `acc_alu`

## Requirements
- R1: After reset `acc_o` is 0x00, `flags_o` is 0x02 and `res_valid_o` is low.
- R2: `in_ready_o` is always high. An opcode and operand are taken on any edge where `in_valid_i` is high. Their effect appears on `acc_o`, `flags_o` and `res_o` one edge later. `res_valid_o` is high for exactly that one cycle per accepted operation.
- R3: Opcode 0 (load) copies the operand into the accumulator and onto `res_o`, and leaves `flags_o` unchanged.
- R4: Opcode 1 (add) and opcode 2 (add with carry in from CY) write A+B(+CY) mod 256 to the accumulator. CY is the carry out of bit 7. AC is the carry out of bit 3.
- R5: Opcode 3 (subtract) and opcode 4 (subtract with borrow in from CY) write A-B(-CY) mod 256 to the accumulator. CY is set when a borrow occurs (A < B+borrow). AC is the carry out of bit 3 in the two's-complement sum A + ~B + (1-borrow).
- R6: Opcode 8 (compare) sets every flag exactly as opcode 3 would and puts the difference on `res_o`. The accumulator keeps its value.
- R7: Opcodes 5, 6 and 7 write A AND B, A OR B and A XOR B respectively. All three clear CY. AND sets AC; OR and XOR clear AC.
- R8: For every operation that writes flags, S equals bit 7 of the result, Z is set exactly when the result is 0x00, and P is set exactly when the result has an even number of 1 bits.
- R9: Opcodes 9 (increment) and 10 (decrement) put B+1 or B-1 mod 256 on `res_o` and leave the accumulator and CY unchanged. AC is set when the low nibble of B is 0xF for increment, and when the low nibble of B is non-zero for decrement.
- R10: The flag byte is packed, from bit 7 to bit 0, as S, Z, 0, AC, 0, P, 1, CY.
- R11: Opcodes 11 to 15 leave the accumulator and flags unchanged and drive `res_o` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Opcode and operand are offered |
| in_ready_o | output | 1 | Always high; the block accepts every offer |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Second operand byte |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Packed status byte |
| res_o | output | 8 | Result of the last executed operation |
| res_valid_o | output | 1 | One-cycle pulse when `res_o` is new |

## Verification
Two functions can land in the same execute cycle: the carry coming in from the previous operation and the nibble carry or borrow produced by the current one. Add with carry and subtract with borrow take CY from whatever operation ran before. The sweep therefore reloads the accumulator with a load, which keeps the flags, and runs every opcode over a grid of accumulator and operand values. Each opcode thus meets both carry states together with nibble carries and byte wraps. Every result is judged against an arithmetic model held in the bench, comparing accumulator, packed flags, result and strobe together.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int DW = 8;
  localparam int NW = DW / 2;

  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SBB  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CMP  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10
  } alu_op_e;

  localparam int FB_CY = 0;
  localparam int FB_P  = 2;
  localparam int FB_AC = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;
  localparam logic [7:0] FLAGS_RST = 8'b0000_0010;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W  = 8,
  parameter int NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ac_o,
  output logic         cy_o
);
  localparam int HW = W - NW;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [NW:0]   lo;
  logic [HW:0]   hi;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~cin_i : cin_i;
    lo    = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
    hi    = {1'b0, a_i[W-1:NW]} + {1'b0, b_eff[W-1:NW]} + {{HW{1'b0}}, lo[NW]};
    sum_o = {hi[HW-1:0], lo[NW-1:0]};
    ac_o  = lo[NW];
    cy_o  = sub_i ? ~hi[HW] : hi[HW];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         ac_i,
  input  logic         cy_i,
  output logic [7:0]   flags_o
);
  import acc_alu_pkg::*;

  always_comb begin
    flags_o        = FLAGS_RST;
    flags_o[FB_S]  = res_i[W-1];
    flags_o[FB_Z]  = (res_i == '0);
    flags_o[FB_AC] = ac_i;
    flags_o[FB_P]  = ~^res_i;
    flags_o[FB_CY] = cy_i;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = acc_alu_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] operand_i,
  output logic [DW-1:0] acc_o,
  output logic [7:0]    flags_o,
  output logic [DW-1:0] res_o,
  output logic          res_valid_o
);
  import acc_alu_pkg::*;

  localparam int NWL = DW / 2;

  logic [DW-1:0] tmp_q, acc_q, res_q;
  logic [3:0]    op_q;
  logic          exec_q, res_valid_q;
  logic [7:0]    flags_q;

  assign in_ready_o = 1'b1;

  // capture stage: operand into the hidden temporary register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q  <= '0;
      op_q   <= '0;
      exec_q <= 1'b0;
    end else begin
      exec_q <= in_valid_i;
      if (in_valid_i) begin
        tmp_q <= operand_i;
        op_q  <= op_i;
      end
    end
  end

  // operand steering for the shared adder
  logic [DW-1:0] ar_a, ar_b, ar_sum, lg_y;
  logic          ar_cin, ar_sub, ar_ac, ar_cy;
  logic [1:0]    lg_sel;

  always_comb begin
    ar_a   = acc_q;
    ar_b   = tmp_q;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    lg_sel = 2'd0;
    case (op_q)
      OP_ADC: ar_cin = flags_q[FB_CY];
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin
        ar_sub = 1'b1;
        ar_cin = flags_q[FB_CY];
      end
      OP_INC: begin
        ar_a   = tmp_q;
        ar_b   = '0;
        ar_cin = 1'b1;
      end
      OP_DEC: begin
        ar_a   = tmp_q;
        ar_b   = {{(DW-1){1'b0}}, 1'b1};
        ar_sub = 1'b1;
      end
      OP_OR:  lg_sel = 2'd1;
      OP_XOR: lg_sel = 2'd2;
      default: ;
    endcase
  end

  alu_arith #(.W(DW), .NW(NWL)) u_arith (
    .a_i(ar_a), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
    .sum_o(ar_sum), .ac_o(ar_ac), .cy_o(ar_cy)
  );

  alu_logic #(.W(DW)) u_logic (
    .a_i(acc_q), .b_i(tmp_q), .sel_i(lg_sel), .y_o(lg_y)
  );

  // result and flag selection
  logic [DW-1:0] result;
  logic          wr_acc, wr_flags, is_logic, ac_sel, cy_sel;
  logic [7:0]    flags_new;

  always_comb begin
    result   = '0;
    wr_acc   = 1'b0;
    wr_flags = 1'b0;
    is_logic = 1'b0;
    case (op_q)
      OP_LOAD: begin
        result = tmp_q;
        wr_acc = 1'b1;
      end
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result   = ar_sum;
        wr_acc   = 1'b1;
        wr_flags = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result   = lg_y;
        wr_acc   = 1'b1;
        wr_flags = 1'b1;
        is_logic = 1'b1;
      end
      OP_CMP, OP_INC, OP_DEC: begin
        result   = ar_sum;
        wr_flags = 1'b1;
      end
      default: ;
    endcase
    ac_sel = is_logic ? (op_q == OP_AND) : ar_ac;
    if (op_q == OP_INC || op_q == OP_DEC) cy_sel = flags_q[FB_CY];
    else if (is_logic)                    cy_sel = 1'b0;
    else                                  cy_sel = ar_cy;
  end

  alu_flags #(.W(DW)) u_flags (
    .res_i(result), .ac_i(ac_sel), .cy_i(cy_sel), .flags_o(flags_new)
  );

  // execute stage: architectural state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      flags_q     <= FLAGS_RST;
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= exec_q;
      if (exec_q) begin
        res_q <= result;
        if (wr_acc)   acc_q   <= result;
        if (wr_flags) flags_q <= flags_new;
      end
    end
  end

  assign acc_o       = acc_q;
  assign flags_o     = flags_q;
  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;

  a_r2_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(exec_q));
  a_r3_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && op_q == OP_LOAD) |=> $stable(flags_o));
  a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && op_q == OP_CMP) |=> $stable(acc_o));
  a_r8_zero_matches_res: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && wr_flags) |=> (flags_o[FB_Z] == (res_o == '0)));
  a_r9_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && (op_q == OP_INC || op_q == OP_DEC)) |=> $stable(flags_o[FB_CY]) && $stable(acc_o));
  a_r11_undef_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && op_q > 4'd10) |=> $stable(acc_o) && $stable(flags_o) && res_o == '0);
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc, flags, res;
  logic       res_valid;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_flg = 8'h02;

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .operand_i(operand), .acc_o(acc), .flags_o(flags),
    .res_o(res), .res_valid_o(res_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1, 2: return "R4/R8/R10";
      3, 4: return "R5/R8/R10";
      5, 6, 7: return "R7/R8/R10";
      8: return "R6/R8/R10";
      9, 10: return "R9/R8/R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [7:0] pack(input int r, input int ac, input int cy);
    logic [7:0] rb;
    rb = r[7:0];
    return {rb[7], rb == 8'h00, 1'b0, ac[0], 1'b0, ~^rb, 1'b1, cy[0]};
  endfunction

  task automatic do_op(input int o, input int b);
    int a, c, r, ac, cy, s;
    logic [7:0] e_acc, e_flg, e_res;
    a = m_acc; c = m_flg[0];
    e_acc = m_acc; e_flg = m_flg; e_res = 8'h00;
    case (o)
      0: begin e_acc = b[7:0]; e_res = b[7:0]; end
      1, 2: begin
        if (o == 1) c = 0;
        s = a + b + c; r = s & 255;
        ac = ((a & 15) + (b & 15) + c) > 15 ? 1 : 0;
        cy = s > 255 ? 1 : 0;
        e_acc = r[7:0]; e_res = r[7:0]; e_flg = pack(r, ac, cy);
      end
      3, 4, 8: begin
        if (o != 4) c = 0;
        s = a - b - c; r = s & 255;
        ac = ((a & 15) + ((~b) & 15) + (1 - c)) > 15 ? 1 : 0;
        cy = s < 0 ? 1 : 0;
        if (o != 8) e_acc = r[7:0];
        e_res = r[7:0]; e_flg = pack(r, ac, cy);
      end
      5, 6, 7: begin
        r = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
        ac = (o == 5) ? 1 : 0;
        e_acc = r[7:0]; e_res = r[7:0]; e_flg = pack(r, ac, 0);
      end
      9: begin
        r = (b + 1) & 255; ac = ((b & 15) == 15) ? 1 : 0;
        e_res = r[7:0]; e_flg = pack(r, ac, m_flg[0]);
      end
      10: begin
        r = (b + 255) & 255; ac = ((b & 15) != 0) ? 1 : 0;
        e_res = r[7:0]; e_flg = pack(r, ac, m_flg[0]);
      end
      default: ;
    endcase
    @(negedge clk);
    op = o[3:0]; operand = b[7:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({acc, flags, res, res_valid} == {e_acc, e_flg, e_res, 1'b1}, tag_of(o),
        {7'd0, acc, flags, res, res_valid}, {7'd0, e_acc, e_flg, e_res, 1'b1});
    m_acc = e_acc; m_flg = e_flg;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({acc, flags, res_valid} == {8'h00, 8'h02, 1'b0}, "R1",
        {15'd0, acc, flags, res_valid}, {15'd0, 8'h00, 8'h02, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 ready", in_ready, 1);

    // R2: single pulse per operation, latency of two edges
    do_op(0, 8'h5A);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 pulse width", res_valid, 0);

    // directed corners: nibble carry with byte wrap, carry chained into ADC
    do_op(0, 8'hFF); do_op(1, 8'h01); do_op(2, 8'h00);
    do_op(0, 8'h00); do_op(3, 8'h01); do_op(4, 8'h00);
    do_op(0, 8'h80); do_op(8, 8'h80); do_op(9, 8'hFF); do_op(10, 8'h00);
    do_op(0, 8'h0F); do_op(1, 8'h01); do_op(5, 8'h00); do_op(6, 8'h00);
    for (int u = 11; u < 16; u++) do_op(u, 8'h3C);
    // R10: fixed bits of the packed byte
    chk(flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b1, "R10",
        flags, {m_flg[7:6], 1'b0, m_flg[4], 1'b0, m_flg[2], 1'b1, m_flg[0]});

    // sweep over a grid of accumulator and operand values
    for (int a = 0; a < 256; a += 9) begin
      for (int b = 0; b < 256; b += 11) begin
        for (int o = 1; o <= 10; o++) begin
          do_op(0, a);
          do_op(o, b);
        end
        do_op(11 + ((a + b) % 5), b);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule